// File: doc/BRIEF.md
# Horizontal Video Window Decimator

This block sits on an active-video pixel stream and turns each scan line into a narrower line. A horizontal sync input, whose sense can be flipped by a polarity bit, restarts a pixel position counter. Only valid pixels whose position falls between a programmable first and last position are passed on. Of those, a drop count D in the range 0 to 63 removes D pixels out of every group of 64. The kept pixels are spread evenly over the group by a phase accumulator.

Before a pixel leaves the block it is smoothed by a box filter. The filter averages the current pixel with up to four earlier window pixels of the same line. The number of taps is chosen from D, so that heavier decimation gets stronger low-pass filtering. Each emitted pixel is marked by a one-cycle valid strobe. A one-cycle line-done pulse marks the point where the last window position has been consumed.

Software sizes the window outside this block. It uses a target width W, an active width A, a kept count of ceil(W*64/A) and a crop centred on an even pixel. The block itself only sees the resulting start, end and drop values.

Top module: `hwin_decimator`

## Requirements
- R1: The effective sync is `hsync_in XOR hs_invert`. While the effective sync is 1, the position counter is cleared to 0, and any pixel presented in that cycle is ignored.
- R2: Valid pixels after the sync take positions 0, 1, 2 and so on. Only positions p with win_start <= p <= win_end are window pixels. Other pixels produce no output, and a window with win_end < win_start produces nothing.
- R3: With K = 64 - drop_count, the window pixel with 0-based index i is emitted exactly when floor((i+1)*K/64) > floor(i*K/64). This keeps K of every 64 window pixels.
- R4: With drop_count = 0, every window pixel is emitted.
- R5: filt_taps is 5 when drop_count >= 48, 4 when it is >= 32, 3 when it is >= 16, and 1 otherwise.
- R6: out_data is floor(S/T), where T = filt_taps and S is the sum of the current window pixel and the T-1 window pixels before it on the same line. A missing earlier pixel at the start of a line counts as the first window pixel of that line.
- R7: An emitted pixel appears on out_valid/out_data in the clock cycle after it is presented. out_valid is high for one cycle per emitted pixel.
- R8: line_done pulses for one cycle in the cycle after the pixel at position win_end is accepted. It pulses whether or not that pixel is emitted.
- R9: The decimation phase and the filter history restart at the first window pixel of every line. Nothing carries over from the previous line.
- R10: After reset, out_valid, line_done and out_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Input pixel present this cycle |
| pix_data | input | DW | Input pixel value |
| hsync_in | input | 1 | Raw horizontal sync |
| hs_invert | input | 1 | 1 inverts the sense of hsync_in |
| win_start | input | PW | First window position, inclusive |
| win_end | input | PW | Last window position, inclusive |
| drop_count | input | 6 | Pixels dropped per group of 64 |
| filt_taps | output | 3 | Box filter length chosen from drop_count |
| out_valid | output | 1 | Emitted pixel strobe |
| out_data | output | DW | Filtered emitted pixel |
| line_done | output | 1 | Pulse after the last window position |

## Verification
The bench runs lines longer than one 64-pixel group. The drop counts it uses sit on each side of every tap threshold (0, 1, 15, 16, 31, 32, 47, 48, 63). This separates a wrong accumulator wrap from a wrong filter choice. Lines are repeated with the sync inverted, with gaps in pix_valid and with junk pixels during sync. These runs tell apart counting positions by cycle from counting them by valid pixel, and show whether the polarity handling is correct. A window starting at 0, a window longer than the line and an empty window exercise the bounds. Back-to-back lines that use different data expose any phase or filter history left over from the previous line.

// File: rtl/hwd_pkg.sv
`timescale 1ns/1ps
package hwd_pkg;
  localparam int GRP_W    = 6;
  localparam int GROUP    = 1 << GRP_W;
  localparam int MAX_TAPS = 5;
  localparam int TAP_W    = 3;

  // filter length chosen from the number of pixels dropped per group
  function automatic logic [TAP_W-1:0] taps_for_drop(input logic [GRP_W-1:0] d);
    if (d >= GRP_W'(48))      return TAP_W'(5);
    else if (d >= GRP_W'(32)) return TAP_W'(4);
    else if (d >= GRP_W'(16)) return TAP_W'(3);
    else                      return TAP_W'(1);
  endfunction

  // pixels kept per group of GROUP
  function automatic logic [GRP_W:0] kept_for_drop(input logic [GRP_W-1:0] d);
    return (GRP_W+1)'(GROUP) - {1'b0, d};
  endfunction
endpackage

// File: rtl/hwd_window.sv
`timescale 1ns/1ps
module hwd_window #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic          hsync_in,
  input  logic          hs_invert,
  input  logic [PW-1:0] hstart,
  input  logic [PW-1:0] hend,
  output logic          sync_act,
  output logic          win_hit,
  output logic          win_first,
  output logic          win_last
);
  localparam logic [PW-1:0] POS_MAX = '1;

  logic [PW-1:0] pos_q;
  logic          take;

  assign sync_act  = hsync_in ^ hs_invert;
  assign take      = pix_valid & ~sync_act;
  assign win_hit   = take && (pos_q >= hstart) && (pos_q <= hend);
  assign win_first = win_hit && (pos_q == hstart);
  assign win_last  = win_hit && (pos_q == hend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         pos_q <= '0;
    else if (sync_act)                  pos_q <= '0;
    else if (take && pos_q != POS_MAX)  pos_q <= pos_q + 1'b1;
  end

  // R1: an active sync leaves the position counter at zero
  assert_sync_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_act |=> (pos_q == '0));
endmodule

// File: rtl/hwd_phase.sv
`timescale 1ns/1ps
module hwd_phase
  import hwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             first,
  input  logic [GRP_W-1:0] drop,
  output logic             emit
);
  logic [GRP_W-1:0] acc_q;
  logic [GRP_W:0]   kept;
  logic [GRP_W:0]   base;
  logic [GRP_W:0]   sum;

  assign kept = kept_for_drop(drop);
  assign base = first ? '0 : {1'b0, acc_q};
  assign sum  = base + kept;
  // crossing a full group means the top bit is set
  assign emit = hit && sum[GRP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (hit) acc_q <= sum[GRP_W-1:0];
  end

  // R4: nothing dropped when the drop count is zero
  assert_full_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && drop == '0) |-> emit);
  // R3/R9: restarted phase drops the first pixel whenever anything is dropped
  assert_first_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && first && drop != '0) |-> !emit);
endmodule

// File: rtl/hwd_fir.sv
`timescale 1ns/1ps
module hwd_fir
  import hwd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             first,
  input  logic [DW-1:0]    pix,
  input  logic [TAP_W-1:0] taps,
  output logic [DW-1:0]    avg
);
  localparam int HD = MAX_TAPS - 1;
  localparam int SW = DW + 3;

  logic [DW-1:0] hist_q [HD];
  logic [DW-1:0] smp    [MAX_TAPS];
  logic [SW-1:0] sum;
  logic [SW-1:0] quo;

  function automatic logic [SW-1:0] div_taps(input logic [SW-1:0] s,
                                              input logic [TAP_W-1:0] t);
    case (t)
      TAP_W'(3): return s / SW'(3);
      TAP_W'(4): return s >> 2;
      TAP_W'(5): return s / SW'(5);
      default:   return s;
    endcase
  endfunction

  assign smp[0] = pix;

  for (genvar k = 0; k < HD; k++) begin : g_hist
    assign smp[k+1] = first ? pix : hist_q[k];
    if (k == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hist_q[k] <= '0;
        else if (hit) hist_q[k] <= pix;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hist_q[k] <= '0;
        else if (hit) hist_q[k] <= first ? pix : hist_q[k-1];
      end
    end
  end

  always_comb begin
    sum = '0;
    for (int j = 0; j < MAX_TAPS; j++)
      if (j < int'(taps)) sum = sum + SW'(smp[j]);
  end

  assign quo = div_taps(sum, taps);
  assign avg = quo[DW-1:0];

  // R6: a single tap passes the pixel through unchanged
  assert_single_tap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && taps == TAP_W'(1)) |-> (avg == pix));
endmodule

// File: rtl/hwin_decimator.sv
`timescale 1ns/1ps
module hwin_decimator
  import hwd_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic [DW-1:0]    pix_data,
  input  logic             hsync_in,
  input  logic             hs_invert,
  input  logic [PW-1:0]    win_start,
  input  logic [PW-1:0]    win_end,
  input  logic [GRP_W-1:0] drop_count,
  output logic [TAP_W-1:0] filt_taps,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic             line_done
);
  logic          sync_act;
  logic          win_hit;
  logic          win_first;
  logic          win_last;
  logic          emit;
  logic [DW-1:0] avg;

  assign filt_taps = taps_for_drop(drop_count);

  hwd_window #(.PW(PW)) u_window (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .hsync_in(hsync_in),
    .hs_invert(hs_invert), .hstart(win_start), .hend(win_end),
    .sync_act(sync_act), .win_hit(win_hit), .win_first(win_first),
    .win_last(win_last)
  );

  hwd_phase u_phase (
    .clk(clk), .rst_n(rst_n), .hit(win_hit), .first(win_first),
    .drop(drop_count), .emit(emit)
  );

  hwd_fir #(.DW(DW)) u_fir (
    .clk(clk), .rst_n(rst_n), .hit(win_hit), .first(win_first),
    .pix(pix_data), .taps(filt_taps), .avg(avg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      line_done <= 1'b0;
    end else begin
      out_valid <= emit;
      line_done <= win_last;
      if (emit) out_data <= avg;
    end
  end

  // R2: output only follows a pixel inside the window
  assert_out_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(win_hit));
  // R7: output strobe lags the phase decision by one cycle
  assert_emit_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(emit));
  // R8: line end pulse follows the last window position
  assert_done_after_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> $past(win_last));
  // R5: light decimation leaves the filter bypassed
  assert_light_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count < GRP_W'(16)) |-> (filt_taps == TAP_W'(1)));
endmodule

// File: tb/hwin_decimator_test.sv
`timescale 1ns/1ps
module hwin_decimator_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_valid = 1'b0;
  logic [7:0] pix_data = '0;
  logic       hsync_in = 1'b0;
  logic       hs_invert = 1'b0;
  logic [7:0] win_start = '0;
  logic [7:0] win_end = '0;
  logic [5:0] drop_count = '0;
  logic [2:0] filt_taps;
  logic       out_valid;
  logic [7:0] out_data;
  logic       line_done;

  int total = 0;
  int bad = 0;
  int seen = 0;

  // bench model state
  int mpos = 0;
  int ev = 0, ed = 0, edata = 0;
  int lp [0:255];

  always #2.5 clk = ~clk;

  hwin_decimator #(.DW(8), .PW(8)) uut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .hsync_in(hsync_in), .hs_invert(hs_invert), .win_start(win_start),
    .win_end(win_end), .drop_count(drop_count), .filt_taps(filt_taps),
    .out_valid(out_valid), .out_data(out_data), .line_done(line_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int btaps(input int d);
    if (d < 16) return 1;
    if (d < 32) return 3;
    if (d < 48) return 4;
    return 5;
  endfunction

  // arithmetic model of the requirements, updated on the edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mpos = 0; ev = 0; ed = 0; edata = 0;
    end else begin
      ev = 0; ed = 0;
      if ((hsync_in ^ hs_invert) == 1'b1) mpos = 0;             // R1
      else if (pix_valid) begin
        if (mpos >= int'(win_start) && mpos <= int'(win_end)) begin
          int idx, k, t, s;
          idx = mpos - int'(win_start);
          lp[idx] = int'(pix_data);
          k = 64 - int'(drop_count);
          ev = (((idx + 1) * k) / 64 > (idx * k) / 64) ? 1 : 0;   // R3
          t = btaps(int'(drop_count));
          s = 0;
          for (int j = 0; j < t; j++) s += (idx - j >= 0) ? lp[idx - j] : lp[0];
          if (ev == 1) edata = s / t;                             // R6
          ed = (mpos == int'(win_end)) ? 1 : 0;                   // R8
        end
        if (mpos < 255) mpos++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(out_valid == ev[0], "R3/R7", int'(out_valid), ev);
      if (ev == 1) check(int'(out_data) == edata, "R6", int'(out_data), edata);
      check(line_done == ed[0], "R8", int'(line_done), ed);
      if (out_valid) seen++;
    end
  end

  task automatic run_line(input int st, input int en, input int d, input bit inv,
                          input int npix, input int seed, input bit gap,
                          input string req);
    int nw, last, expn;
    @(negedge clk);
    seen = 0;
    win_start = 8'(st); win_end = 8'(en); drop_count = 6'(d); hs_invert = inv;
    hsync_in = ~inv; pix_valid = 1'b1; pix_data = 8'hAA;   // junk during sync, R1
    @(negedge clk);
    @(negedge clk);
    hsync_in = inv;
    for (int p = 0; p < npix; p++) begin
      if (gap && (p % 4 == 3)) begin
        pix_valid = 1'b0; pix_data = 8'h55;
        @(negedge clk);
      end
      pix_valid = 1'b1;
      pix_data = 8'((p * seed + (p >> 2) * 7 + seed * 3) & 255);
      @(negedge clk);
    end
    pix_valid = 1'b0;
    repeat (3) @(negedge clk);
    last = (en < npix - 1) ? en : npix - 1;
    nw = last - st + 1;
    if (nw < 0) nw = 0;
    expn = (nw * (64 - d)) / 64;
    check(seen == expn, req, seen, expn);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(out_valid == 1'b0, "R10", int'(out_valid), 0);
    check(line_done == 1'b0, "R10", int'(line_done), 0);
    check(out_data == 8'd0, "R10", int'(out_data), 0);
    // R5: full sweep of the tap selection
    for (int d = 0; d < 64; d++) begin
      drop_count = 6'(d);
      #1;
      check(int'(filt_taps) == btaps(d), "R5", int'(filt_taps), btaps(d));
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R4: nothing dropped, every window pixel counted
    run_line(3, 72, 0, 1'b0, 80, 5, 1'b0, "R4");
    run_line(3, 72, 1, 1'b1, 80, 9, 1'b0, "R1");
    run_line(3, 72, 15, 1'b0, 80, 13, 1'b1, "R2");
    run_line(3, 72, 16, 1'b1, 80, 17, 1'b0, "R1");
    run_line(3, 72, 31, 1'b0, 80, 21, 1'b0, "R2");
    run_line(3, 72, 32, 1'b0, 80, 29, 1'b1, "R2");
    run_line(3, 72, 47, 1'b1, 80, 31, 1'b1, "R1");
    run_line(3, 72, 48, 1'b0, 80, 37, 1'b0, "R2");
    run_line(3, 72, 63, 1'b0, 80, 41, 1'b0, "R2");
    // R9: same settings, new data, nothing carried over
    run_line(3, 72, 63, 1'b0, 80, 77, 1'b0, "R9");
    run_line(5, 90, 40, 1'b0, 100, 43, 1'b1, "R2");
    run_line(5, 90, 40, 1'b0, 100, 91, 1'b0, "R9");
    // window edges
    run_line(0, 9, 20, 1'b0, 30, 47, 1'b0, "R2");
    run_line(10, 200, 8, 1'b1, 40, 53, 1'b0, "R2");
    run_line(20, 10, 0, 1'b0, 40, 59, 1'b0, "R2");
    run_line(7, 7, 0, 1'b0, 20, 61, 1'b0, "R8");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule